// File: doc/BRIEF.md
# Vector Subelement Swizzle Unit

This unit reorders the lanes of a short vector of four equal-width subelements. An 8-bit control byte holds four 2-bit selectors. Each selector names the source lane that feeds one output lane. The unit moves raw bit patterns, so integer and floating-point swizzles share one datapath. A 1-bit type flag travels alongside the data, and downstream logic uses it to route the result.

An active subvector length gates the permutation. When the length is zero, the source is copied through untouched. When the length is between 1 and 3, only the output lanes below that length are permuted, and the higher lanes keep their own source value. When the length is 4 or more, all four lanes are permuted. Setting all four selectors to the same index spreads that source element across every lane. The result, the type flag and a valid strobe are registered, so they appear one clock after a valid input.

Top module: `subelem_swizzle`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `is_fp_o` and `dst_o` are all zero.
- R2: `valid_o` equals the value `valid_i` had at the previous rising clock edge.
- R3: When a swizzle applies to output lane k (k = 0..3), that lane is source lane j. Here j is `ctrl_i[2k+1:2k]`, output lane k is `dst_o[k*W+W-1:k*W]` and source lane j is `src_i[j*W+W-1:j*W]`, with W the element width. Lane 0 is driven by bits 1:0 and lane 3 by bits 7:6.
- R4: With all four selectors equal to i and a length of 4, every output lane equals source lane i (control 8'h00, 8'h55, 8'hAA or 8'hFF).
- R5: With `subvl_i` equal to 0, `dst_o` equals `src_i` for any control byte.
- R6: With `subvl_i` between 1 and 3, output lanes below `subvl_i` follow R3, and lanes at or above it equal their own source lane.
- R7: With `subvl_i` between 4 and 7, all four lanes follow R3.
- R8: `is_fp_o` carries the `is_fp_i` value of the accepted operation. The flag has no effect on `dst_o`.
- R9: A cycle with `valid_i` low leaves `dst_o` and `is_fp_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| is_fp_i | input | 1 | Type flag: 1 = floating point, 0 = integer |
| subvl_i | input | 3 | Active subvector length |
| ctrl_i | input | 8 | Packed lane selectors |
| src_i | input | 4*ELEM_W | Source vector, lane 0 in the low bits |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| is_fp_o | output | 1 | Registered type flag |
| dst_o | output | 4*ELEM_W | Registered permuted vector |

## Verification
The bound checker tests these behaviours on every cycle:
- the one-cycle valid latency;
- result and flag holding on idle cycles;
- plain copy at zero length;
- forwarding of the type flag;
- the lane-0 selector;
- pass-through of lane 3 under a partial length.

Only the directed scenarios show the following:
- complete permutations such as reversal and broadcast;
- the exact lane boundary for each partial length;
- lengths above four;
- the cleared state under reset.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned CTRL_W = LANES * SEL_W;
  localparam int unsigned LEN_W  = 3;
endpackage

// File: rtl/swz_lane_enable.sv
module swz_lane_enable
  import swz_pkg::*;
(
  input  logic [LEN_W-1:0] subvl_i,
  output logic [LANES-1:0] act_o
);
  // lanes below the length are permuted; length 0 disables all; >= LANES enables all
  for (genvar k = 0; k < LANES; k++) begin : g_act
    assign act_o[k] = (subvl_i != '0) && (subvl_i > LEN_W'(k));
  end
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
  import swz_pkg::*;
#(
  parameter int unsigned ELEM_W   = 32,
  parameter int unsigned LANE_IDX = 0
) (
  input  logic [LANES*ELEM_W-1:0] src_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    act_i,
  output logic [ELEM_W-1:0]       lane_o
);
  logic [ELEM_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int j = 0; j < LANES; j++) begin
      if (sel_i == SEL_W'(j)) picked = src_i[j*ELEM_W +: ELEM_W];
    end
  end

  assign lane_o = act_i ? picked : src_i[LANE_IDX*ELEM_W +: ELEM_W];
endmodule

// File: rtl/swz_out_reg.sv
module swz_out_reg
  import swz_pkg::*;
#(
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned VEC_W = LANES * ELEM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             fp_i,
  input  logic [VEC_W-1:0] data_i,
  output logic             valid_o,
  output logic             fp_o,
  output logic [VEC_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fp_o    <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        fp_o   <= fp_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/subelem_swizzle.sv
module subelem_swizzle
  import swz_pkg::*;
#(
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned VEC_W = LANES * ELEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              is_fp_i,
  input  logic [LEN_W-1:0]  subvl_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [VEC_W-1:0]  src_i,
  output logic              valid_o,
  output logic              is_fp_o,
  output logic [VEC_W-1:0]  dst_o
);
  logic [LANES-1:0] lane_act;
  logic [VEC_W-1:0] perm;

  swz_lane_enable u_en (
    .subvl_i (subvl_i),
    .act_o   (lane_act)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    swz_lane_mux #(.ELEM_W(ELEM_W), .LANE_IDX(k)) u_mux (
      .src_i  (src_i),
      .sel_i  (ctrl_i[k*SEL_W +: SEL_W]),
      .act_i  (lane_act[k]),
      .lane_o (perm[k*ELEM_W +: ELEM_W])
    );
  end

  swz_out_reg #(.ELEM_W(ELEM_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (valid_i),
    .fp_i    (is_fp_i),
    .data_i  (perm),
    .valid_o (valid_o),
    .fp_o    (is_fp_o),
    .data_o  (dst_o)
  );
endmodule

// File: rtl/swz_checker.sv
module swz_checker
  import swz_pkg::*;
#(
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned VEC_W = LANES * ELEM_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              is_fp_i,
  input logic [LEN_W-1:0]  subvl_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [VEC_W-1:0]  src_i,
  input logic              valid_o,
  input logic              is_fp_o,
  input logic [VEC_W-1:0]  dst_o
);
  logic [ELEM_W-1:0] exp_l0;
  assign exp_l0 = src_i[ctrl_i[1:0]*ELEM_W +: ELEM_W];

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(dst_o) && $stable(is_fp_o)));

  assert_zero_len_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && subvl_i == '0) |=> dst_o == $past(src_i));

  assert_fp_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> is_fp_o == $past(is_fp_i));

  assert_lane0_select_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && subvl_i != '0) |=> dst_o[ELEM_W-1:0] == $past(exp_l0));

  assert_upper_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && subvl_i != '0 && subvl_i < LEN_W'(LANES)) |=>
      dst_o[VEC_W-1 -: ELEM_W] == $past(src_i[VEC_W-1 -: ELEM_W]));
endmodule

bind subelem_swizzle swz_checker #(.ELEM_W(ELEM_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .is_fp_i (is_fp_i),
  .subvl_i (subvl_i),
  .ctrl_i  (ctrl_i),
  .src_i   (src_i),
  .valid_o (valid_o),
  .is_fp_o (is_fp_o),
  .dst_o   (dst_o)
);

// File: tb/sim_subelem_swizzle.sv
module sim_subelem_swizzle;
  localparam int W = 32;
  localparam int N = 4;
  localparam int VW = N * W;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic is_fp_i = 1'b0;
  logic [2:0] subvl_i = '0;
  logic [7:0] ctrl_i = '0;
  logic [VW-1:0] src_i = '0;
  logic valid_o, is_fp_o;
  logic [VW-1:0] dst_o;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subelem_swizzle #(.ELEM_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .is_fp_i(is_fp_i),
    .subvl_i(subvl_i), .ctrl_i(ctrl_i), .src_i(src_i),
    .valid_o(valid_o), .is_fp_o(is_fp_o), .dst_o(dst_o)
  );

  localparam logic [VW-1:0] PAT_A = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
  localparam logic [VW-1:0] PAT_B = {32'h80000000, 32'h3F800000, 32'h12345678, 32'hFFFFFFFF};

  function automatic logic [VW-1:0] model(logic [VW-1:0] s, logic [7:0] c, logic [2:0] len);
    logic [VW-1:0] r;
    for (int k = 0; k < N; k++) begin
      if (len != 0 && (len >= 4 || k < int'(len)))
        r[k*W +: W] = s[int'(c[2*k +: 2])*W +: W];
      else
        r[k*W +: W] = s[k*W +: W];
    end
    return r;
  endfunction

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one op; returns at the negedge after the capturing posedge
  task automatic run_op(logic [VW-1:0] s, logic [7:0] c, logic [2:0] len, logic fp);
    @(negedge clk);
    src_i = s; ctrl_i = c; subvl_i = len; is_fp_i = fp; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid_o", VW'(valid_o), '0);
    check("R1 is_fp_o", VW'(is_fp_o), '0);
    check("R1 dst_o", dst_o, '0);
  endtask

  task automatic t_latency();
    run_op(PAT_A, 8'hE4, 3'd4, 1'b0);
    check("R2 valid_o high", VW'(valid_o), VW'(1));
    @(negedge clk);
    check("R2 valid_o low", VW'(valid_o), '0);
  endtask

  task automatic t_full_perms();
    run_op(PAT_A, 8'hE4, 3'd4, 1'b0);
    check("R3 identity", dst_o, PAT_A);
    run_op(PAT_A, 8'h1B, 3'd4, 1'b0);
    check("R3 reverse", dst_o, {PAT_A[31:0], PAT_A[63:32], PAT_A[95:64], PAT_A[127:96]});
    run_op(PAT_B, 8'h4E, 3'd4, 1'b0);
    check("R3 swap halves", dst_o, model(PAT_B, 8'h4E, 3'd4));
  endtask

  task automatic t_broadcast();
    for (int i = 0; i < N; i++) begin
      logic [7:0] c;
      c = {4{2'(i)}};
      run_op(PAT_A, c, 3'd4, 1'b0);
      check("R4 broadcast", dst_o, {4{PAT_A[i*W +: W]}});
    end
  endtask

  task automatic t_zero_len();
    run_op(PAT_A, 8'h1B, 3'd0, 1'b0);
    check("R5 zero length copy", dst_o, PAT_A);
    run_op(PAT_B, 8'hFF, 3'd0, 1'b1);
    check("R5 zero length copy fp", dst_o, PAT_B);
  endtask

  task automatic t_partial();
    for (int len = 1; len < 4; len++) begin
      run_op(PAT_A, 8'h1B, 3'(len), 1'b0);
      check("R6 partial length", dst_o, model(PAT_A, 8'h1B, 3'(len)));
    end
    run_op(PAT_A, 8'h1B, 3'd2, 1'b0);
    check("R6 len2 explicit", dst_o, {PAT_A[127:96], PAT_A[95:64], PAT_A[95:64], PAT_A[127:96]});
  endtask

  task automatic t_over_len();
    for (int len = 5; len < 8; len++) begin
      run_op(PAT_A, 8'h1B, 3'(len), 1'b0);
      check("R7 length above four", dst_o, model(PAT_A, 8'h1B, 3'd4));
    end
  endtask

  task automatic t_fp_flag();
    run_op(PAT_B, 8'h39, 3'd4, 1'b1);
    check("R8 fp flag set", VW'(is_fp_o), VW'(1));
    check("R8 fp data unchanged", dst_o, model(PAT_B, 8'h39, 3'd4));
    run_op(PAT_B, 8'h39, 3'd4, 1'b0);
    check("R8 fp flag clear", VW'(is_fp_o), '0);
  endtask

  task automatic t_hold();
    logic [VW-1:0] prev;
    run_op(PAT_A, 8'h1B, 3'd4, 1'b1);
    prev = dst_o;
    @(negedge clk);
    src_i = PAT_B; ctrl_i = 8'h00; subvl_i = 3'd0; is_fp_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 data held", dst_o, prev);
    check("R9 fp held", VW'(is_fp_o), VW'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_latency();
    t_full_perms();
    t_broadcast();
    t_zero_len();
    t_partial();
    t_over_len();
    t_fp_flag();
    t_hold();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule